// File: doc/BRIEF.md
# Dual-Bank Data Register with Boundary-Scan Wrapper

The block holds two independent 9-bit banks of rising-edge data flip-flops, named A and B. Each bank has its own clock and its own active-low output-enable pin. Each tri-state output is modelled as a data bit plus an enable flag. Around the banks sits a 42-cell boundary-scan register. Observe-only cells sit on every input pin. Controlling cells sit on every output and on the internal active-high enable of each bank.

A separate TAP controller drives the capture, shift and update strobes, the serial input and a 3-bit instruction class. Under the pass-through classes the banks drive the outputs directly. While they do, the chain can still capture pin values and preload its hold stage. Under the test classes the hold stage takes over the outputs, or all outputs are switched off.

Top module: `dual_byte_bscan_reg`

## Requirements
- R1: On a rising edge of its own clock, a bank stores its 9 data inputs. An edge on one bank's clock leaves the other bank unchanged. Reset clears both banks to 0.
- R2: Under instruction classes 0 (bypass) and 1 (sample/preload), and under any code above 4, each bank's outputs carry its stored bits. All 9 of its enable flags equal the inverse of its enable pin.
- R3: Changing an enable pin never changes the stored bits. Re-enabling shows the old values again.
- R4: With the shift strobe high, every rising TCK moves the chain one place toward bit 0. The serial input enters at bit 41, and tdo_o shows bit 0. A bit takes 42 shifts to reach tdo_o.
- R5: On a rising TCK with the capture strobe high, the chain loads the following positions. Bit 41 takes the A enable pin, bit 40 the A clock and bit 39 the internal A enable. Bit 38 takes the B enable pin, bit 37 the B clock and bit 36 the internal B enable. Bits 35 down to 27 take A inputs 0 to 8, and bits 26 down to 18 take B inputs 0 to 8. Bits 17 down to 9 take stored A bits 0 to 8, and bits 8 down to 0 take stored B bits 0 to 8.
- R6: The internal enable cells capture the active-high form of the bank enable, which is the inverse of the pin.
- R7: On a falling TCK with the update strobe high, the controlling cells copy the shift stage into their hold latches. At any other time the hold latches do not change, so shifting does not disturb the outputs under a test class.
- R8: Under class 2 (extest) or class 3 (clamp), A output i takes hold bit 17-i and B output i takes hold bit 8-i. All A enable flags take hold bit 39, and all B enable flags take hold bit 36.
- R9: Under class 4 (highz), all 18 enable flags are 0. The banks still store data on their clocks.
- R10: Capture and preload under class 1 leave the outputs driven by the banks.
- R11: Reset clears the shift stage and the hold latches. After reset, tdo_o is 0, and a test class drives zeros with all enable flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_clk_i | input | 1 | Bank A clock |
| a_oe_ni | input | 1 | Bank A output enable pin, active low |
| a_d_i | input | 9 | Bank A data inputs |
| b_clk_i | input | 1 | Bank B clock |
| b_oe_ni | input | 1 | Bank B output enable pin, active low |
| b_d_i | input | 9 | Bank B data inputs |
| tck_i | input | 1 | Test clock |
| capture_i | input | 1 | Capture strobe from TAP |
| shift_i | input | 1 | Shift strobe from TAP |
| update_i | input | 1 | Update strobe from TAP |
| tdi_i | input | 1 | Serial scan input |
| mode_i | input | 3 | Instruction class: 0 bypass, 1 sample, 2 extest, 3 clamp, 4 highz |
| a_q_o | output | 9 | Bank A output data |
| a_en_o | output | 9 | Bank A output enable flags |
| b_q_o | output | 9 | Bank B output data |
| b_en_o | output | 9 | Bank B output enable flags |
| tdo_o | output | 1 | Serial scan output (chain bit 0) |

## Verification
A cell placed at the wrong chain position shows up in two ways. The captured vector read out at tdo_o has a misplaced bit within 42 shifts. Under extest, the wrong output or enable flag takes a preloaded value right after the next falling-edge update. A hold latch that loads outside update would change the outputs partway through a shift, and a mid-shift sample catches that. A bank storing on the wrong clock or losing data when its enable changes shows on its outputs at the next sample.

// File: rtl/bscan_dreg_pkg.sv
package bscan_dreg_pkg;
  localparam int unsigned BANK_W = 9;

  typedef enum logic [2:0] {
    INS_BYPASS = 3'd0,
    INS_SAMPLE = 3'd1,
    INS_EXTEST = 3'd2,
    INS_CLAMP  = 3'd3,
    INS_HIGHZ  = 3'd4
  } ins_class_e;
endpackage

// File: rtl/bdr_core_bank.sv
module bdr_core_bank #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  // R1
  bank_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o == $past(d_i));
endmodule

// File: rtl/bdr_scan_chain.sv
module bdr_scan_chain #(
  parameter int unsigned W = 9
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         tdi_i,
  input  logic         a_oe_ni,
  input  logic         a_clk_i,
  input  logic [W-1:0] a_d_i,
  input  logic [W-1:0] a_core_q_i,
  input  logic         b_oe_ni,
  input  logic         b_clk_i,
  input  logic [W-1:0] b_d_i,
  input  logic [W-1:0] b_core_q_i,
  output logic [W-1:0] a_hold_q_o,
  output logic         a_hold_en_o,
  output logic [W-1:0] b_hold_q_o,
  output logic         b_hold_en_o,
  output logic         tdo_o
);
  localparam int unsigned LEN       = 4*W + 6;
  localparam int unsigned A_PIN_POS = LEN - 1;
  localparam int unsigned A_CLK_POS = LEN - 2;
  localparam int unsigned A_EN_POS  = LEN - 3;
  localparam int unsigned B_PIN_POS = LEN - 4;
  localparam int unsigned B_CLK_POS = LEN - 5;
  localparam int unsigned B_EN_POS  = LEN - 6;
  localparam int unsigned A_IN_MSB  = 4*W - 1;
  localparam int unsigned B_IN_MSB  = 3*W - 1;
  localparam int unsigned A_OUT_MSB = 2*W - 1;
  localparam int unsigned B_OUT_MSB = W - 1;

  logic [LEN-1:0] cap;
  logic [LEN-1:0] sr_q;

  assign cap[A_PIN_POS] = a_oe_ni;
  assign cap[A_CLK_POS] = a_clk_i;
  assign cap[A_EN_POS]  = ~a_oe_ni;
  assign cap[B_PIN_POS] = b_oe_ni;
  assign cap[B_CLK_POS] = b_clk_i;
  assign cap[B_EN_POS]  = ~b_oe_ni;

  for (genvar i = 0; i < W; i++) begin : g_cells
    assign cap[A_IN_MSB-i]  = a_d_i[i];
    assign cap[B_IN_MSB-i]  = b_d_i[i];
    assign cap[A_OUT_MSB-i] = a_core_q_i[i];
    assign cap[B_OUT_MSB-i] = b_core_q_i[i];
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= cap;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[LEN-1:1]};
  end

  assign tdo_o = sr_q[0];

  // hold latches exist only behind controlling cells
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hold_q_o  <= '0;
      b_hold_q_o  <= '0;
      a_hold_en_o <= 1'b0;
      b_hold_en_o <= 1'b0;
    end else if (update_i) begin
      a_hold_en_o <= sr_q[A_EN_POS];
      b_hold_en_o <= sr_q[B_EN_POS];
      for (int i = 0; i < int'(W); i++) begin
        a_hold_q_o[i] <= sr_q[A_OUT_MSB-i];
        b_hold_q_o[i] <= sr_q[B_OUT_MSB-i];
      end
    end
  end

  // R4
  shift_move_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sr_q[LEN-1] == $past(tdi_i)) && (tdo_o == $past(sr_q[1])));

  // R7
  hold_steady_chk: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(a_hold_q_o) && $stable(b_hold_q_o)
                  && $stable(a_hold_en_o) && $stable(b_hold_en_o));
endmodule

// File: rtl/bdr_out_ctrl.sv
module bdr_out_ctrl
  import bscan_dreg_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] core_q_i,
  input  logic         oe_ni,
  input  logic [W-1:0] hold_q_i,
  input  logic         hold_en_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] en_o
);
  ins_class_e ins;
  assign ins = ins_class_e'(mode_i);

  always_comb begin
    unique case (ins)
      INS_EXTEST, INS_CLAMP: begin
        q_o  = hold_q_i;
        en_o = {W{hold_en_i}};
      end
      INS_HIGHZ: begin
        q_o  = core_q_i;
        en_o = '0;
      end
      default: begin
        q_o  = core_q_i;
        en_o = {W{~oe_ni}};
      end
    endcase
  end

  // R9
  highz_off_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i == INS_HIGHZ) |-> (en_o == '0));

  // R8
  test_drive_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i == INS_EXTEST || mode_i == INS_CLAMP) |-> (q_o == hold_q_i) && ($countones(en_o) == (hold_en_i ? W : 0)));

  // R2
  pass_drive_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode_i == INS_BYPASS || mode_i == INS_SAMPLE) |-> (q_o == core_q_i) && ($countones(en_o) == (oe_ni ? 0 : W)));
endmodule

// File: rtl/dual_byte_bscan_reg.sv
module dual_byte_bscan_reg
  import bscan_dreg_pkg::*;
#(
  parameter int unsigned W = BANK_W
) (
  input  logic         rst_ni,
  input  logic         a_clk_i,
  input  logic         a_oe_ni,
  input  logic [W-1:0] a_d_i,
  input  logic         b_clk_i,
  input  logic         b_oe_ni,
  input  logic [W-1:0] b_d_i,
  input  logic         tck_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         tdi_i,
  input  logic [2:0]   mode_i,
  output logic [W-1:0] a_q_o,
  output logic [W-1:0] a_en_o,
  output logic [W-1:0] b_q_o,
  output logic [W-1:0] b_en_o,
  output logic         tdo_o
);
  logic [W-1:0] a_core_q, b_core_q;
  logic [W-1:0] a_hold_q, b_hold_q;
  logic         a_hold_en, b_hold_en;

  bdr_core_bank #(.W(W)) i_bank_a (
    .clk_i(a_clk_i), .rst_ni(rst_ni), .d_i(a_d_i), .q_o(a_core_q)
  );

  bdr_core_bank #(.W(W)) i_bank_b (
    .clk_i(b_clk_i), .rst_ni(rst_ni), .d_i(b_d_i), .q_o(b_core_q)
  );

  bdr_scan_chain #(.W(W)) i_chain (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .tdi_i      (tdi_i),
    .a_oe_ni    (a_oe_ni),
    .a_clk_i    (a_clk_i),
    .a_d_i      (a_d_i),
    .a_core_q_i (a_core_q),
    .b_oe_ni    (b_oe_ni),
    .b_clk_i    (b_clk_i),
    .b_d_i      (b_d_i),
    .b_core_q_i (b_core_q),
    .a_hold_q_o (a_hold_q),
    .a_hold_en_o(a_hold_en),
    .b_hold_q_o (b_hold_q),
    .b_hold_en_o(b_hold_en),
    .tdo_o      (tdo_o)
  );

  bdr_out_ctrl #(.W(W)) i_out_a (
    .tck_i(tck_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .core_q_i(a_core_q), .oe_ni(a_oe_ni),
    .hold_q_i(a_hold_q), .hold_en_i(a_hold_en),
    .q_o(a_q_o), .en_o(a_en_o)
  );

  bdr_out_ctrl #(.W(W)) i_out_b (
    .tck_i(tck_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .core_q_i(b_core_q), .oe_ni(b_oe_ni),
    .hold_q_i(b_hold_q), .hold_en_i(b_hold_en),
    .q_o(b_q_o), .en_o(b_en_o)
  );
endmodule

// File: tb/test_dual_byte_bscan_reg.sv
module test_dual_byte_bscan_reg;
  localparam logic [2:0] M_BYP = 3'd0, M_SMP = 3'd1, M_EXT = 3'd2, M_CLP = 3'd3, M_HIZ = 3'd4;

  // {clk mask(b1=B,b0=A), a_d, b_d, a_oe_n, b_oe_n, exp a_q, exp b_q, exp a_en bit, exp b_en bit}
  localparam logic [41:0] VEC [6] = '{
    {2'b11, 9'h1A5, 9'h0F3, 1'b0, 1'b0, 9'h1A5, 9'h0F3, 1'b1, 1'b1},
    {2'b01, 9'h055, 9'h1FF, 1'b0, 1'b1, 9'h055, 9'h0F3, 1'b1, 1'b0},
    {2'b10, 9'h000, 9'h123, 1'b1, 1'b0, 9'h055, 9'h123, 1'b0, 1'b1},
    {2'b00, 9'h1FF, 9'h1FF, 1'b1, 1'b1, 9'h055, 9'h123, 1'b0, 1'b0},
    {2'b00, 9'h1FF, 9'h1FF, 1'b0, 1'b0, 9'h055, 9'h123, 1'b1, 1'b1},
    {2'b11, 9'h100, 9'h001, 1'b0, 1'b0, 9'h100, 9'h001, 1'b1, 1'b1}
  };

  logic       rst_ni = 1'b0, tck = 1'b0;
  logic       a_clk = 1'b0, b_clk = 1'b0, a_oe_n = 1'b0, b_oe_n = 1'b0;
  logic [8:0] a_d = '0, b_d = '0;
  logic       capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic [2:0] mode = M_BYP;
  logic [8:0] a_q, a_en, b_q, b_en;
  logic       tdo;
  int         n_chk = 0, n_bad = 0;

  dual_byte_bscan_reg i_dual_byte_bscan_reg (
    .rst_ni(rst_ni), .a_clk_i(a_clk), .a_oe_ni(a_oe_n), .a_d_i(a_d),
    .b_clk_i(b_clk), .b_oe_ni(b_oe_n), .b_d_i(b_d), .tck_i(tck),
    .capture_i(capture), .shift_i(shift), .update_i(update), .tdi_i(tdi),
    .mode_i(mode), .a_q_o(a_q), .a_en_o(a_en), .b_q_o(b_q), .b_en_o(b_en),
    .tdo_o(tdo)
  );

  always #10 tck = ~tck;

  task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #5;
  endtask

  task automatic pulse(input logic [1:0] m);
    #1 a_clk = m[0]; b_clk = m[1];
    #2 a_clk = 1'b0; b_clk = 1'b0;
    #1;
  endtask

  // expected test-class outputs from a hold image, per R8
  task automatic chk_hold_out(input string req, input logic [41:0] h);
    logic [8:0] eaq, ebq;
    for (int i = 0; i < 9; i++) begin
      eaq[i] = h[17-i];
      ebq[i] = h[8-i];
    end
    chk({req, " a_q"}, a_q, eaq);
    chk({req, " b_q"}, b_q, ebq);
    chk({req, " a_en"}, a_en, {9{h[39]}});
    chk({req, " b_en"}, b_en, {9{h[36]}});
  endtask

  function automatic logic [41:0] mk_cap(logic aoe, logic acl, logic boe, logic bcl,
                                         logic [8:0] ad, logic [8:0] bd,
                                         logic [8:0] aq, logic [8:0] bq);
    logic [41:0] c;
    c[41] = aoe; c[40] = acl; c[39] = ~aoe;
    c[38] = boe; c[37] = bcl; c[36] = ~boe;
    for (int i = 0; i < 9; i++) begin
      c[35-i] = ad[i];
      c[26-i] = bd[i];
      c[17-i] = aq[i];
      c[8-i]  = bq[i];
    end
    return c;
  endfunction

  task automatic scan_dr(input logic [41:0] din, input logic peek, input logic [41:0] peek_h,
                         output logic [41:0] dout);
    capture = 1'b1; tick(); capture = 1'b0; shift = 1'b1;
    for (int i = 0; i < 42; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      if (peek && i == 20) chk_hold_out("R7 mid-shift", peek_h);
      tick();
    end
    shift = 1'b0; update = 1'b1; tick(); update = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [41:0] dout, exp_cap, pat;
    logic [41:0] din1, din2;
    din1 = {2'b01, 4'b1000, 9'h1C3, 9'h0A6, 9'h15A, 9'h0E7};
    din2 = {2'b10, 4'b0001, 9'h000, 9'h1FF, 9'h0C3, 9'h13C};

    tick(); tick();
    rst_ni = 1'b1;
    tick();
    // R11 / R1 reset state
    chk("R1 reset a_q", a_q, 0);
    chk("R1 reset b_q", b_q, 0);
    chk("R2 reset a_en", a_en, 9'h1FF);
    chk("R2 reset b_en", b_en, 9'h1FF);
    chk("R11 reset tdo", tdo, 0);

    // R1 R2 R3 table walk
    foreach (VEC[k]) begin
      a_d = VEC[k][39:31]; b_d = VEC[k][30:22];
      a_oe_n = VEC[k][21]; b_oe_n = VEC[k][20];
      pulse(VEC[k][41:40]);
      #1;
      chk($sformatf("R1 R3 vec%0d a_q", k), a_q, VEC[k][19:11]);
      chk($sformatf("R1 R3 vec%0d b_q", k), b_q, VEC[k][10:2]);
      chk($sformatf("R2 vec%0d a_en", k), a_en, {9{VEC[k][1]}});
      chk($sformatf("R2 vec%0d b_en", k), b_en, {9{VEC[k][0]}});
    end
    tick();

    // R4 raw shift: 42 bits in, same 42 bits out in order
    pat = 42'h2_9C3A_5E71_B4;
    shift = 1'b1;
    for (int i = 0; i < 42; i++) begin tdi = pat[i]; tick(); end
    for (int i = 0; i < 42; i++) begin dout[i] = tdo; tdi = 1'b0; tick(); end
    shift = 1'b0;
    chk("R4 chain length/order", dout, pat);

    // R5 R6 R10 capture under sample with preload
    a_d = 9'h0B2; b_d = 9'h14D; a_oe_n = 1'b0; b_oe_n = 1'b1; mode = M_SMP;
    exp_cap = mk_cap(1'b0, 1'b0, 1'b1, 1'b0, 9'h0B2, 9'h14D, 9'h100, 9'h001);
    scan_dr(din1, 1'b0, '0, dout);
    chk("R5 captured vector", dout, exp_cap);
    chk("R6 internal enables", {dout[39], dout[36]}, 2'b10);
    chk("R6 stored-bit cells", {dout[17:9], dout[8:0]}, {9'h001, 9'h100});
    #1;
    chk("R10 a_q", a_q, 9'h100);
    chk("R10 a_en", a_en, 9'h1FF);
    chk("R10 b_en", b_en, 9'h000);

    // R8 extest from preloaded hold, R7 during second scan
    mode = M_EXT;
    #1 chk_hold_out("R8 extest din1", din1);
    scan_dr(din2, 1'b1, din1, dout);
    chk("R6 capture under extest", {dout[39], dout[36]}, 2'b10);
    #1 chk_hold_out("R8 extest din2", din2);
    mode = M_CLP;
    #1 chk_hold_out("R8 clamp din2", din2);

    // R9 highz: all off, bank still stores
    mode = M_HIZ;
    a_oe_n = 1'b0; b_oe_n = 1'b0;
    #1;
    chk("R9 highz a_en", a_en, 0);
    chk("R9 highz b_en", b_en, 0);
    a_d = 9'h0AA;
    pulse(2'b01);
    mode = M_BYP;
    #1;
    chk("R9 stored under highz", a_q, 9'h0AA);
    chk("R2 after highz a_en", a_en, 9'h1FF);
    mode = 3'd6;
    #1 chk("R2 unused code acts as bypass", b_en, 9'h1FF);
    mode = M_BYP;

    // R11 reset clears hold and shift stage
    tick();
    rst_ni = 1'b0;
    #1;
    mode = M_EXT;
    #1;
    chk("R11 hold cleared a_en", a_en, 0);
    chk("R11 hold cleared a_q", a_q, 0);
    chk("R11 tdo cleared", tdo, 0);
    chk("R1 bank cleared", i_dual_byte_bscan_reg.b_q_o | b_q, 0);
    mode = M_BYP;
    #1;
    chk("R1 bank a cleared", a_q, 0);
    tick();
    rst_ni = 1'b1;
    tick();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule